// File: doc/BRIEF.md
# Serial Peripheral Master with Chip-Select Framing Control

This block is a single-channel SPI master (mode 0) for a host that reaches it through a small register port. The host queues 32-bit words into an eight-entry transmit FIFO. The engine sends each word as one burst of a programmable bit count, taken from the low end of the word and shifted out most significant bit first. The bits it samples back are pushed as one word per burst into an eight-entry receive FIFO, which the host drains by reading a data register.

Two controls decide how a queue of words becomes traffic on the wire:

- **Start mode.** Traffic begins either as soon as the transmit FIFO holds a word, or only after the host writes an exchange command. The exchange command stays set until the whole queue has gone out.
- **Framing mode.** The slave-select line either stays low across consecutive bursts until the queue runs out, or is raised after each burst for a programmed number of idle serial-clock periods before the next burst begins.

Top module: `spim_top`

Register map (`reg_addr`):

| Address | Register | Access |
|---|---|---|
| 0 | CTRL | read/write |
| 1 | WAIT | read/write |
| 2 | TX | write pushes the transmit FIFO |
| 3 | RX | read pops the receive FIFO |
| 4 | STATUS | read; write 1 to bit 3 clears the overflow flag |

CTRL fields:

| Bits | Field |
|---|---|
| [4:0] | burst length minus one |
| [5] | auto start |
| [6] | gap framing |
| [7] | exchange |
| [11:8] | half divider minus one |

STATUS bits:

| Bit | Meaning |
|---|---|
| [0] | busy |
| [1] | TX empty |
| [2] | TX full |
| [3] | RX overflow |
| [4] | RX not empty |

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, CTRL reads 0 and STATUS reads 0x2 (transmit FIFO empty, nothing else set).
- R2: With CTRL[4:0] = L-1, each burst has exactly L rising `sclk` edges. On those edges `mosi` carries word bits L-1 down to 0 in that order. Word bits at L and above are never sent.
- R3: Each completed burst pushes one word into the receive FIFO. The word holds the L sampled `miso` bits right-aligned, with the first sampled bit in position L-1, and zeros above. A read of address 3 returns and removes the oldest word.
- R4: The serial clock idles low. Its period is D = 2·(CTRL[11:8]+1) system clocks. `mosi` changes only while `sclk` is low.
- R5: With CTRL[6] = 0, all words queued before the start go out in one slave-select frame. The frame closes only when the transmit FIFO is empty.
- R6: With CTRL[6] = 1, every burst has its own frame. Between frames `cs_n` stays high for exactly W·D+1 system clocks, where W = WAIT[7:0] (W = 0 gives one clock).
- R7: `cs_n` falls D system clocks before the first rising `sclk` edge of a frame, and rises D system clocks after the last falling edge.
- R8: With CTRL[5] = 1, a burst starts whenever the transmit FIFO is non-empty.
- R9: With CTRL[5] = 0, queued words are not sent until 1 is written to CTRL[7]. That bit then reads 1 until the queue has drained and the engine is idle, after which it reads 0.
- R10: A burst that completes while the receive FIFO holds 8 words is dropped, and STATUS[3] is set. STATUS[3] stays set until 1 is written to STATUS bit 3.
- R11: STATUS[0] reads 1 from the first slave-select assertion until the final frame has closed with the transmit FIFO empty. It is always 1 while `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX at address 3) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Active-low slave select |

## Verification
The hardest situation to reach is a receive overflow. The receive FIFO and the transmit FIFO are the same depth, so a ninth burst can exist only if a ninth word is pushed after the engine has pulled the first word but before the queue finishes. The bench therefore queues eight words with the engine held off, releases it by enabling auto start, and waits for the transmit full flag to drop before pushing the ninth word. It then confirms the sticky flag and the order of the eight words that were kept.

The gap length at W = 0 and the lead and trail times at the fastest divider are reached by sweeping burst length, divider, framing mode and wait count. A loopback slave (optionally inverting) provides the receive data.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int WORD_W = 32;
    localparam int LEN_W  = $clog2(WORD_W);
    localparam int HDIV_W = 4;
    localparam int WAIT_W = 8;

    typedef enum logic [2:0] {
        ADR_CTRL = 3'd0,
        ADR_WAIT = 3'd1,
        ADR_TX   = 3'd2,
        ADR_RX   = 3'd3,
        ADR_STAT = 3'd4
    } adr_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_GAP
    } st_e;

    typedef struct packed {
        logic [HDIV_W-1:0] half_m1;
        logic              gap_mode;
        logic              auto_start;
        logic [LEN_W-1:0]  len_m1;
    } cfg_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);
    assign dout  = q.mem[q.rp];

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            d.mem[q.wp] = din;
            d.wp        = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [HDIV_W-1:0] half_m1,
    input  logic              gap_mode,
    input  logic [WAIT_W-1:0] wait_n,
    input  logic              go,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              busy
);
    typedef struct packed {
        st_e               st;
        logic [HDIV_W-1:0] div;
        logic              sclk;
        logic [LEN_W-1:0]  bitcnt;
        logic [WORD_W-1:0] tx_sh;
        logic [WORD_W-1:0] rx_sh;
        logic [WAIT_W:0]   cnt;
    } eng_t;

    eng_t             q, d;
    logic             tick, can_next;
    logic [LEN_W-1:0] shamt;

    assign sclk    = q.sclk;
    assign mosi    = q.tx_sh[WORD_W-1];
    assign cs_n    = (q.st == ST_IDLE) || (q.st == ST_GAP);
    assign busy    = (q.st != ST_IDLE);
    assign rx_word = q.rx_sh;

    always_comb begin
        d        = q;
        tx_pop   = 1'b0;
        rx_push  = 1'b0;
        tick     = (q.st != ST_IDLE) && (q.div == half_m1);
        can_next = go && tx_valid;
        // align the burst so its top bit sits at the shift-out end
        shamt    = LEN_W'(WORD_W - 1) - len_m1;
        if (q.st != ST_IDLE) d.div = tick ? '0 : q.div + 1'b1;
        case (q.st)
            ST_IDLE: begin
                if (can_next) begin
                    tx_pop   = 1'b1;
                    d.st     = ST_LEAD;
                    d.div    = '0;
                    d.tx_sh  = tx_word << shamt;
                    d.rx_sh  = '0;
                    d.bitcnt = '0;
                    d.cnt    = '0;
                end
            end
            ST_LEAD: begin
                if (tick) d.st = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk  = 1'b1;
                        d.rx_sh = {q.rx_sh[WORD_W-2:0], miso};
                    end else begin
                        d.sclk = 1'b0;
                        if (q.bitcnt == len_m1) begin
                            rx_push = 1'b1;
                            if (!gap_mode && can_next) begin
                                tx_pop   = 1'b1;
                                d.tx_sh  = tx_word << shamt;
                                d.rx_sh  = '0;
                                d.bitcnt = '0;
                            end else begin
                                d.st  = ST_TRAIL;
                                d.cnt = '0;
                            end
                        end else begin
                            d.bitcnt = q.bitcnt + 1'b1;
                            d.tx_sh  = {q.tx_sh[WORD_W-2:0], 1'b0};
                        end
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    if (q.cnt[0]) begin
                        d.cnt = '0;
                        d.st  = (gap_mode && can_next) ? ST_GAP : ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (!tx_valid) begin
                    d.st = ST_IDLE;
                end else if (q.cnt == {wait_n, 1'b0}) begin
                    tx_pop   = 1'b1;
                    d.st     = ST_LEAD;
                    d.div    = '0;
                    d.tx_sh  = tx_word << shamt;
                    d.rx_sh  = '0;
                    d.bitcnt = '0;
                    d.cnt    = '0;
                end else if (tick) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int B_AUTO = LEN_W;
    localparam int B_GAP  = LEN_W + 1;
    localparam int B_XCH  = LEN_W + 2;
    localparam int B_HDIV = LEN_W + 3;
    localparam int B_OVF  = 3;

    typedef struct packed {
        cfg_t              cfg;
        logic [WAIT_W-1:0] wait_n;
        logic              xch;
        logic              ovf;
    } reg_t;

    reg_t              q, d;
    logic              tx_push, tx_pop, tx_full, tx_empty;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic              busy, ovf_clr, wr_ctrl, wr_wait;

    assign wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
    assign wr_wait = reg_wr && (reg_addr == ADR_WAIT);
    assign ovf_clr = reg_wr && (reg_addr == ADR_STAT) && reg_wdata[B_OVF];
    assign tx_push = reg_wr && (reg_addr == ADR_TX) && !tx_full;
    assign rx_pop  = reg_rd && (reg_addr == ADR_RX) && !rx_empty;

    spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(reg_wdata),
        .pop(tx_pop), .dout(tx_head), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
        .pop(rx_pop), .dout(rx_head), .full(rx_full), .empty(rx_empty)
    );

    spim_engine u_eng (
        .clk(clk), .rst_n(rst_n),
        .len_m1(q.cfg.len_m1), .half_m1(q.cfg.half_m1),
        .gap_mode(q.cfg.gap_mode), .wait_n(q.wait_n),
        .go(q.cfg.auto_start || q.xch),
        .tx_valid(!tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word),
        .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy)
    );

    always_comb begin
        d = q;
        // exchange completes once the queue is empty and the engine is idle
        if (q.xch && !busy && tx_empty) d.xch = 1'b0;
        if (wr_ctrl) begin
            d.cfg.len_m1     = reg_wdata[LEN_W-1:0];
            d.cfg.auto_start = reg_wdata[B_AUTO];
            d.cfg.gap_mode   = reg_wdata[B_GAP];
            d.cfg.half_m1    = reg_wdata[B_HDIV +: HDIV_W];
            if (reg_wdata[B_XCH]) d.xch = 1'b1;
        end
        if (wr_wait) d.wait_n = reg_wdata[WAIT_W-1:0];
        if (ovf_clr) d.ovf = 1'b0;
        if (rx_push && rx_full) d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            ADR_CTRL: reg_rdata = WORD_W'({q.cfg.half_m1, q.xch, q.cfg.gap_mode,
                                           q.cfg.auto_start, q.cfg.len_m1});
            ADR_WAIT: reg_rdata = WORD_W'(q.wait_n);
            ADR_RX:   reg_rdata = rx_head;
            ADR_STAT: reg_rdata = WORD_W'({!rx_empty, q.ovf, tx_full, tx_empty, busy});
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spim_sva.sv
module spim_sva (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic mosi,
    input logic cs_n,
    input logic busy,
    input logic xch,
    input logic auto_start,
    input logic ovf,
    input logic ovf_clr,
    input logic rx_push,
    input logic rx_full
);
    assert_sclk_low_outside_frame_R4: assert property (
        @(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);

    assert_mosi_steady_while_high_R4: assert property (
        @(posedge clk) disable iff (!rst_n) sclk |-> $stable(mosi));

    assert_busy_during_frame_R11: assert property (
        @(posedge clk) disable iff (!rst_n) !cs_n |-> busy);

    assert_xch_clears_only_idle_R9: assert property (
        @(posedge clk) disable iff (!rst_n) $fell(xch) |-> !busy);

    assert_start_needs_command_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !$past(auto_start)) |-> $past(xch));

    assert_overflow_sets_R10: assert property (
        @(posedge clk) disable iff (!rst_n) (rx_push && rx_full) |=> ovf);

    assert_overflow_sticky_R10: assert property (
        @(posedge clk) disable iff (!rst_n) (ovf && !ovf_clr) |=> ovf);
endmodule

bind spim_top spim_sva u_sva (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .busy(busy), .xch(q.xch), .auto_start(q.cfg.auto_start), .ovf(q.ovf),
    .ovf_clr(ovf_clr), .rx_push(rx_push), .rx_full(rx_full)
);

// File: tb/tb_spim_top.sv
`timescale 1ns/1ps
module tb_spim_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, cs_n, miso;
    logic        inv = 1'b0;

    assign miso = mosi ^ inv;

    always #2.5 clk = ~clk;

    spim_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // wire monitor, sampled on the falling system-clock edge
    int   cyc = 0, exp_d = 2;
    logic p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;
    int   t_fall = 0, t_rise = 0, t_lastf = 0, t_lastr = 0;
    int   nfr = 0, nrise = 0, per_err = 0, mosi_err = 0;
    bit   pend = 1'b0;
    logic bitbuf [0:4095];
    int   leads  [0:1023];
    int   trails [0:1023];
    int   gaps   [0:1023];

    always @(negedge clk) begin
        cyc++;
        if (p_cs && !cs_n) begin
            gaps[nfr % 1024] = cyc - t_rise;
            nfr++;
            t_fall = cyc;
            pend = 1'b1;
        end
        if (!p_sclk && sclk) begin
            if (pend) begin
                leads[(nfr - 1) % 1024] = cyc - t_fall;
                pend = 1'b0;
            end else if (cyc - t_lastr != exp_d) begin
                per_err++;
            end
            t_lastr = cyc;
            bitbuf[nrise % 4096] = mosi;
            nrise++;
        end
        if (p_sclk && sclk && (mosi !== p_mosi)) mosi_err++;
        if (p_sclk && !sclk) t_lastf = cyc;
        if (!p_cs && cs_n) begin
            trails[(nfr - 1) % 1024] = cyc - t_lastf;
            t_rise = cyc;
        end
        p_sclk = sclk;
        p_cs   = cs_n;
        p_mosi = mosi;
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd4, s);
            if (!s[0] && s[1]) break;
        end
    endtask

    function automatic logic [31:0] mk_word(input int n);
        return (32'(n) * 32'h9E37_79B1) ^ 32'hA5C3_0F69;
    endfunction

    logic [31:0] wv [0:15];
    int          run_id = 0;

    task automatic run_case(input int L, input int h, input bit gapm,
                            input bit auto_m, input int W, input bit iv);
        int          base_fr, base_r, nw, bad, exp_fr;
        logic [31:0] ctrl, mask, v;
        nw     = 3;
        exp_d  = 2 * (h + 1);
        inv    = iv;
        mask   = (L == 32) ? 32'hFFFF_FFFF : ((32'h1 << L) - 1);
        ctrl   = (32'(h) << 8) | (32'(gapm) << 6) | 32'(L - 1);
        wr(3'd1, 32'(W));
        wr(3'd0, ctrl);
        base_fr = nfr; base_r = nrise;
        for (int k = 0; k < nw; k++) begin
            wv[k] = mk_word(run_id * 16 + k + 1);
            wr(3'd2, wv[k]);
        end
        // R8 auto start or R9 exchange command releases the queue
        if (auto_m) wr(3'd0, ctrl | 32'h20);
        else        wr(3'd0, ctrl | 32'h80);
        wait_idle();
        exp_fr = gapm ? nw : 1;
        chk(nfr - base_fr == exp_fr, gapm ? "R6" : "R5", "frame count",
            nfr - base_fr, exp_fr);
        chk(nrise - base_r == nw * L, "R2", "rising edges", nrise - base_r, nw * L);
        bad = 0;
        for (int k = 0; k < nw; k++)
            for (int i = 0; i < L; i++)
                if (bitbuf[(base_r + k * L + i) % 4096] !== wv[k][L - 1 - i]) bad++;
        chk(bad == 0, "R2", "mosi bit mismatches", bad, 0);
        bad = 0;
        for (int f = base_fr; f < nfr; f++) begin
            if (leads[f % 1024] != exp_d)  bad++;
            if (trails[f % 1024] != exp_d) bad++;
        end
        chk(bad == 0, "R7", "lead/trail mismatches", bad, 0);
        bad = 0;
        for (int f = base_fr + 1; f < nfr; f++)
            if (gaps[f % 1024] != W * exp_d + 1) bad++;
        chk(bad == 0, "R6", "gap length mismatches", bad, 0);
        chk(per_err == 0 && mosi_err == 0, "R4", "sclk period / mosi timing errors",
            per_err + mosi_err, 0);
        for (int k = 0; k < nw; k++) begin
            rd(3'd3, v);
            chk(v == ((wv[k] & mask) ^ (iv ? mask : 32'h0)), "R3", "received word",
                v, (wv[k] & mask) ^ (iv ? mask : 32'h0));
        end
        if (!auto_m) begin
            rd(3'd0, v);
            chk(v[7] == 1'b0, "R9", "exchange bit after drain", v[7], 0);
        end
        wr(3'd0, ctrl);
        run_id++;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int          lens [0:4];
        int          waits[0:3];
        int          fr0, it;
        lens  = '{1, 5, 8, 17, 32};
        waits = '{0, 1, 3, 5};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1", "cs_n/sclk after reset", {cs_n, sclk}, 2'b10);
        rd(3'd4, v);
        chk(v == 32'h2, "R1", "STATUS after reset", v, 32'h2);
        rd(3'd0, v);
        chk(v == 32'h0, "R1", "CTRL after reset", v, 32'h0);

        // sweep of length, divider, framing, start mode, wait count, miso polarity
        it = 0;
        for (int li = 0; li < 5; li++)
            for (int h = 0; h < 3; h++)
                for (int g = 0; g < 2; g++) begin
                    run_case(lens[li], h, g[0], it[0], waits[it % 4], it[1]);
                    it++;
                end

        // R9 exchange gating and R11 busy
        exp_d = 4;
        inv   = 1'b0;
        wr(3'd0, 32'h0000_0107);
        fr0 = nfr;
        wr(3'd2, 32'h0000_00C3);
        wr(3'd2, 32'h0000_005A);
        repeat (40) @(negedge clk);
        chk(nfr == fr0 && cs_n == 1'b1, "R9", "frames before exchange", nfr - fr0, 0);
        rd(3'd4, v);
        chk(v[0] == 1'b0, "R11", "busy while held", v[0], 0);
        wr(3'd0, 32'h0000_0187);
        rd(3'd0, v);
        chk(v[7] == 1'b1, "R9", "exchange bit while sending", v[7], 1);
        rd(3'd4, v);
        chk(v[0] == 1'b1, "R11", "busy while sending", v[0], 1);
        wait_idle();
        rd(3'd4, v);
        chk(v[0] == 1'b0, "R11", "busy after drain", v[0], 0);
        chk(nfr - fr0 == 1, "R5", "one frame for exchange", nfr - fr0, 1);
        rd(3'd3, v);
        chk(v == 32'hC3, "R3", "exchange word 0", v, 32'hC3);
        rd(3'd3, v);
        chk(v == 32'h5A, "R3", "exchange word 1", v, 32'h5A);

        // R10 overflow: nine bursts, eight slots
        exp_d = 2;
        wr(3'd0, 32'h0000_0007);
        for (int k = 0; k < 8; k++) begin
            wv[k] = mk_word(900 + k);
            wr(3'd2, wv[k]);
        end
        wr(3'd0, 32'h0000_0027);
        for (int i = 0; i < 200; i++) begin
            rd(3'd4, v);
            if (!v[2]) break;
        end
        wv[8] = mk_word(908);
        wr(3'd2, wv[8]);
        wait_idle();
        rd(3'd4, v);
        chk(v[3] == 1'b1, "R10", "overflow flag", v[3], 1);
        for (int k = 0; k < 8; k++) begin
            rd(3'd3, v);
            chk(v == (wv[k] & 32'hFF), "R10", "kept word order", v, wv[k] & 32'hFF);
        end
        rd(3'd4, v);
        chk(v[4] == 1'b0 && v[3] == 1'b1, "R10", "rx empty, flag still set", v[4:3], 2'b01);
        wr(3'd4, 32'h8);
        rd(3'd4, v);
        chk(v[3] == 1'b0, "R10", "overflow cleared", v[3], 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule